// File: doc/BRIEF.md
# Four-Bit Pseudo-Random State Generator

This block steps a four-bit register through a fixed pseudo-random cycle of fifteen non-zero states. Each enabled clock edge moves every bit one place toward bit 0. The vacated top bit takes the exclusive-OR of the two lowest bits. A synchronous reset loads a non-zero starting word. With enable low, the register keeps its value. The state is visible on the output at all times, so the block has no data handshake. Enable is a plain control pin and applies no back-pressure; a consumer that wants a new word simply raises enable for one cycle.

A guard watches for the all-zero word, which a shift-and-XOR register can never leave by itself. If the register ever holds zero, the next enabled edge reloads a restart word instead of shifting. In the default build, the reset word and the restart word are both 1101.

Top module: `lfsr4_prng`

## Requirements
- R1: When `rst` is high at a rising clock edge, `state` becomes the reset word (default 1101) after that edge, whatever `en` is.
- R2: When `rst` is low and `en` is low at a rising edge, `state` keeps its value.
- R3: On an enabled edge from a non-zero state, new `state[2:0]` equals old `state[3:1]` (shift toward bit 0).
- R4: On an enabled edge from a non-zero state, new `state[3]` equals old `state[1]` XOR old `state[0]`.
- R5: From 1101, enabled edges produce exactly 1110, 1111, 0111, 0011, 0001, 1000, 0100, 0010, 1001, 1100, 0110, 1011, 0101, 1010, and then 1101 again.
- R6: The cycle length is 15. A non-zero state never steps to 0000, so 0000 never appears after a non-zero reset word.
- R7: On an enabled edge from 0000, `state` becomes the restart word (default 1101) instead of staying at zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset; loads the reset word |
| en | input | 1 | Step enable; low holds the state |
| state | output | 4 | Current register contents, bit 3 is the MSB |

## Verification
The bench builds two copies of the block. The first uses the defaults, a reset word and a restart word both equal to 1101, and walks the full fifteen-state cycle, holds, and resets in mid-cycle. The second overrides the reset word to 0000 and keeps the restart word at 1101. This puts the otherwise unreachable all-zero state on the output, so the lock-up guard of R7 can be observed directly at the ports.

// File: rtl/lfsr4_pkg.sv
`timescale 1ns/1ps
package lfsr4_pkg;
  localparam int unsigned DEF_WIDTH   = 4;
  localparam int unsigned DEF_TAP_HI  = 1;
  localparam int unsigned DEF_TAP_LO  = 0;
  localparam logic [DEF_WIDTH-1:0] DEF_SEED = 4'b1101;
endpackage

// File: rtl/lfsr4_next.sv
`timescale 1ns/1ps
// Shift toward bit 0 with XOR feedback into the top bit.
module lfsr4_next #(
  parameter int unsigned WIDTH  = 4,
  parameter int unsigned TAP_HI = 1,
  parameter int unsigned TAP_LO = 0
) (
  input  logic [WIDTH-1:0] cur,
  output logic [WIDTH-1:0] nxt
);
  localparam int unsigned TOP = WIDTH - 1;

  for (genvar i = 0; i < TOP; i++) begin : g_shift
    assign nxt[i] = cur[i+1];
  end
  assign nxt[TOP] = cur[TAP_HI] ^ cur[TAP_LO];
endmodule

// File: rtl/lfsr4_guard.sv
`timescale 1ns/1ps
// Replaces the successor of the all-zero word with the restart word.
module lfsr4_guard #(
  parameter int unsigned            WIDTH   = 4,
  parameter logic [WIDTH-1:0]       RESTART = 4'b1101
) (
  input  logic [WIDTH-1:0] cur,
  input  logic [WIDTH-1:0] shifted,
  output logic [WIDTH-1:0] nxt
);
  logic is_zero;
  assign is_zero = ~|cur;
  assign nxt     = is_zero ? RESTART : shifted;
endmodule

// File: rtl/lfsr4_reg.sv
`timescale 1ns/1ps
// State register: synchronous reset wins over enable.
module lfsr4_reg #(
  parameter int unsigned      WIDTH = 4,
  parameter logic [WIDTH-1:0] INIT  = 4'b1101
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)     q <= INIT;
    else if (en) q <= d;
  end
endmodule

// File: rtl/lfsr4_prng.sv
`timescale 1ns/1ps
module lfsr4_prng
  import lfsr4_pkg::*;
#(
  parameter int unsigned      WIDTH        = DEF_WIDTH,
  parameter int unsigned      TAP_HI       = DEF_TAP_HI,
  parameter int unsigned      TAP_LO       = DEF_TAP_LO,
  parameter logic [WIDTH-1:0] RESET_SEED   = DEF_SEED,
  parameter logic [WIDTH-1:0] RESTART_SEED = DEF_SEED
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  output logic [WIDTH-1:0] state
);
  logic [WIDTH-1:0] shifted;
  logic [WIDTH-1:0] next_word;

  lfsr4_next #(.WIDTH(WIDTH), .TAP_HI(TAP_HI), .TAP_LO(TAP_LO)) u_next (
    .cur (state),
    .nxt (shifted)
  );

  lfsr4_guard #(.WIDTH(WIDTH), .RESTART(RESTART_SEED)) u_guard (
    .cur     (state),
    .shifted (shifted),
    .nxt     (next_word)
  );

  lfsr4_reg #(.WIDTH(WIDTH), .INIT(RESET_SEED)) u_reg (
    .clk (clk),
    .rst (rst),
    .en  (en),
    .d   (next_word),
    .q   (state)
  );
endmodule

// File: rtl/lfsr4_checker.sv
`timescale 1ns/1ps
module lfsr4_checker #(
  parameter int unsigned      WIDTH        = 4,
  parameter int unsigned      TAP_HI       = 1,
  parameter int unsigned      TAP_LO       = 0,
  parameter logic [WIDTH-1:0] RESET_SEED   = 4'b1101,
  parameter logic [WIDTH-1:0] RESTART_SEED = 4'b1101
) (
  input logic             clk,
  input logic             rst,
  input logic             en,
  input logic [WIDTH-1:0] state
);
  assert_reset_word_R1: assert property (@(posedge clk)
    rst |=> state == RESET_SEED);

  assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(state));

  assert_shift_down_R3: assert property (@(posedge clk) disable iff (rst)
    (en && state != '0) |=> state[WIDTH-2:0] == $past(state[WIDTH-1:1]));

  assert_feedback_R4: assert property (@(posedge clk) disable iff (rst)
    (en && state != '0) |=> state[WIDTH-1] == ($past(state[TAP_HI]) ^ $past(state[TAP_LO])));

  assert_no_zero_R6: assert property (@(posedge clk) disable iff (rst)
    (state != '0) |=> state != '0);

  assert_unlock_R7: assert property (@(posedge clk) disable iff (rst)
    (en && state == '0) |=> state == RESTART_SEED);
endmodule

bind lfsr4_prng lfsr4_checker #(
  .WIDTH(WIDTH), .TAP_HI(TAP_HI), .TAP_LO(TAP_LO),
  .RESET_SEED(RESET_SEED), .RESTART_SEED(RESTART_SEED)
) u_lfsr4_checker (
  .clk(clk), .rst(rst), .en(en), .state(state)
);

// File: tb/tb_lfsr4_prng.sv
`timescale 1ns/1ps
module tb_lfsr4_prng;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       en  = 1'b0;
  logic [3:0] st_a;
  logic [3:0] st_z;
  int         n_checks = 0;
  int         n_errors = 0;
  bit         finished = 1'b0;

  always #5 clk = ~clk;

  // Default build.
  lfsr4_prng dut (.clk(clk), .rst(rst), .en(en), .state(st_a));
  // Reset word of zero exposes the lock-up guard.
  lfsr4_prng #(.RESET_SEED(4'b0000), .RESTART_SEED(4'b1101)) dut_zero (
    .clk(clk), .rst(rst), .en(en), .state(st_z));

  // Expected cycle from the reset word (R5); entry 15 wraps to the start.
  localparam logic [3:0] SEQ [0:15] = '{
    4'b1101, 4'b1110, 4'b1111, 4'b0111, 4'b0011, 4'b0001, 4'b1000, 4'b0100,
    4'b0010, 4'b1001, 4'b1100, 4'b0110, 4'b1011, 4'b0101, 4'b1010, 4'b1101};

  task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  // Drive at negedge, let one rising edge pass, sample at the next negedge.
  task automatic cycle(input logic r, input logic e);
    rst = r;
    en  = e;
    @(negedge clk);
  endtask

  function automatic logic [3:0] model_step(input logic [3:0] s);
    if (s == 4'b0000) return 4'b1101;
    return {s[1] ^ s[0], s[3:1]};
  endfunction

  initial begin
    logic [3:0] prev;
    int         back_at;
    @(negedge clk);
    cycle(1'b1, 1'b0);
    check("R1 reset word", st_a, 4'b1101);
    check("R1 reset word zero build", st_z, 4'b0000);

    // Table walk of the full cycle.
    for (int k = 1; k < 16; k++) begin
      prev = st_a;
      cycle(1'b0, 1'b1);
      check("R5 sequence", st_a, SEQ[k]);
      check("R3/R4 shift and feedback", st_a, model_step(prev));
    end

    // Hold with enable low for several cycles mid-cycle.
    cycle(1'b0, 1'b1);
    cycle(1'b0, 1'b1);
    cycle(1'b0, 1'b1);
    check("R5 position 3", st_a, SEQ[3]);
    for (int k = 0; k < 4; k++) begin
      cycle(1'b0, 1'b0);
      check("R2 hold", st_a, SEQ[3]);
    end
    cycle(1'b0, 1'b1);
    check("R3 resume after hold", st_a, SEQ[4]);

    // Reset in mid-cycle, with enable high, wins.
    cycle(1'b1, 1'b1);
    check("R1 reset beats enable", st_a, 4'b1101);
    check("R1 zero build reset", st_z, 4'b0000);

    // Lock-up guard: zero build restarts, then follows the cycle.
    cycle(1'b0, 1'b1);
    check("R7 restart from zero", st_z, 4'b1101);
    check("R3 default build one step", st_a, 4'b1110);
    cycle(1'b0, 1'b1);
    check("R4 zero build after restart", st_z, 4'b1110);

    // Period and no-zero check over two full cycles.
    cycle(1'b1, 1'b0);
    back_at = 0;
    for (int k = 1; k <= 30; k++) begin
      cycle(1'b0, 1'b1);
      if (st_a == 4'b0000) check("R6 zero reached", st_a, 4'b0001);
      if (st_a == 4'b1101 && back_at == 0) back_at = k;
    end
    check("R6 period", 4'(back_at), 4'd15);
    check("R6 after two periods", st_a, 4'b1101);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    #2000000;
    if (!finished) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end
endmodule